// File: doc/BRIEF.md
# Folded single-port RAM with column selection

This block is a synchronous single-port RAM of 2048 words, each 16 bits wide. The words are not stored one per entry. They are packed eight to a physical row, which gives 256 rows of 128 bit columns. This keeps a storage array with many words and narrow data at a workable aspect ratio. Every access splits the word address into two parts. The upper part picks a physical row. The lower part picks which 16-bit slice of that row is the addressed word.

On a write, a row decoder turns the row index into one-hot row strobes. Only the addressed 16-bit slice of the strobed row takes the new data. On a read, the whole addressed row is captured into a register on the clock edge. Sixteen 8-to-1 column multiplexers then take the addressed word out of that captured row. A read returns its word one clock after the address is presented. The block has one port and performs one access per cycle. The write enable chooses whether that access is a read or a write.

Top module: `fram_col_ram`

## Requirements
- R1: The RAM stores 2048 independent 16-bit words, at addresses 0 to 2047. A word written at one address is read back unchanged at that address.
- R2: Address bits [10:3] give the physical row and bits [2:0] give the word position p within the row. The word at position p occupies row columns p*16 to p*16+15. The eight positions of one row each hold their own value.
- R3: During a write, the row decoder raises exactly one row strobe, the one equal to the row index. When write enable is low, the decoder raises no strobe.
- R4: A write does not change any row other than the addressed one.
- R5: A write changes only the 16 columns of the addressed word. The other 112 columns of the row keep their previous contents.
- R6: Read data is registered. Consider the address on the port at a rising clock edge. The word stored there appears on `rdata` after that edge and stays there until the next edge.
- R7: During a write cycle, `rdata` after the edge shows the word stored at that address before the write. The new data is visible from the next access onward.
- R8: While `rst_n` is low, `rdata` is held at zero. Reset does not clear the storage array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| addr | input | 11 | Word address: row in [10:3], word position in [2:0] |
| we | input | 1 | 1 = write `wdata` at `addr`, 0 = read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
Every read result is due exactly one rising edge after its address is applied. The bench drives address and data on the falling edge and compares `rdata` at the following falling edge. That is the first point after the single register stage has loaded. A write takes effect at the edge where it is sampled. So the earliest read that can observe the new data is the access presented in the next cycle. For the cycle of the write itself, the bench expects the old contents on `rdata`. The reset value is sampled on falling edges while reset is held low.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_ROW_W  = 8;
  localparam int unsigned DEF_SEL_W  = 3;

  // lowest row column of the word at position sel
  function automatic int unsigned slice_lsb(input int unsigned sel, input int unsigned word_w);
    return sel * word_w;
  endfunction
endpackage

// File: rtl/fram_row_dec.sv
module fram_row_dec #(
  parameter int unsigned ROW_W = 8,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ROW_W-1:0] idx,
  output logic [ROWS-1:0]  strobe
);
  for (genvar r = 0; r < ROWS; r++) begin : g_line
    assign strobe[r] = en && (idx == ROW_W'(r));
  end

  // R3: one strobe for a write, and it matches the index
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(strobe) == 1 && strobe[idx]));
  // R3: silent when not writing
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (strobe == '0));
endmodule

// File: rtl/fram_col_mux.sv
module fram_col_mux #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned WPR      = 1 << SEL_W,
  localparam int unsigned ROW_BITS = WORD_W * WPR
) (
  input  logic [ROW_BITS-1:0] row_bits,
  input  logic [SEL_W-1:0]    sel,
  output logic [WORD_W-1:0]   word
);
  // one WPR:1 selector per output bit, taps spaced WORD_W columns apart
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    logic [WPR-1:0] taps;
    for (genvar w = 0; w < WPR; w++) begin : g_tap
      assign taps[w] = row_bits[w*WORD_W + b];
    end
    assign word[b] = taps[sel];
  end
endmodule

// File: rtl/fram_array.sv
module fram_array #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned ROWS     = 1 << ROW_W,
  localparam int unsigned WPR      = 1 << SEL_W,
  localparam int unsigned ROW_BITS = WORD_W * WPR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_W-1:0]    row_idx,
  input  logic [SEL_W-1:0]    sel,
  input  logic [ROWS-1:0]     row_wen,
  input  logic [WORD_W-1:0]   wdata,
  output logic [ROW_BITS-1:0] row_q,
  output logic [SEL_W-1:0]    sel_q
);
  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] wmask;
  logic [ROW_BITS-1:0] wrep;

  always_comb begin
    wmask = '0;
    wmask[fram_pkg::slice_lsb(int'(sel), WORD_W) +: WORD_W] = '1;
    wrep  = {WPR{wdata}};
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (row_wen[r]) mem[r] <= (mem[r] & ~wmask) | (wrep & wmask);
    end
  end

  // the whole row is captured, old contents on a write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      sel_q <= '0;
    end else begin
      row_q <= mem[row_idx];
      sel_q <= sel;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    // R4: rows without a strobe keep their bits
    a_r4_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !row_wen[r] |=> (mem[r] === $past(mem[r])));
    // R5: outside the word slice nothing moves
    a_r5_slice_only: assert property (@(posedge clk) disable iff (!rst_n)
      row_wen[r] |=> ((mem[r] & ~$past(wmask)) === ($past(mem[r]) & ~$past(wmask))));
  end
endmodule

// File: rtl/fram_col_ram.sv
module fram_col_ram #(
  parameter int unsigned WORD_W = fram_pkg::DEF_WORD_W,
  parameter int unsigned ROW_W  = fram_pkg::DEF_ROW_W,
  parameter int unsigned SEL_W  = fram_pkg::DEF_SEL_W,
  localparam int unsigned ADDR_W   = ROW_W + SEL_W,
  localparam int unsigned ROWS     = 1 << ROW_W,
  localparam int unsigned ROW_BITS = WORD_W * (1 << SEL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [ROW_W-1:0]    row_idx;
  logic [SEL_W-1:0]    word_sel;
  logic [ROWS-1:0]     wr_row_en;
  logic [ROW_BITS-1:0] cap_row;
  logic [SEL_W-1:0]    cap_sel;

  assign row_idx  = addr[ADDR_W-1:SEL_W];
  assign word_sel = addr[SEL_W-1:0];

  fram_row_dec #(.ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(we), .idx(row_idx), .strobe(wr_row_en)
  );

  fram_array #(.WORD_W(WORD_W), .ROW_W(ROW_W), .SEL_W(SEL_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .sel(word_sel),
    .row_wen(wr_row_en), .wdata(wdata), .row_q(cap_row), .sel_q(cap_sel)
  );

  fram_col_mux #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_mux (
    .row_bits(cap_row), .sel(cap_sel), .word(rdata)
  );

  // R6: write then read of the same address returns the written word
  a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (we ##1 (!we && addr == $past(addr))) |=> (rdata == $past(wdata, 2)));
  // R8: read data is zero when reset releases
  a_r8_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> (rdata == '0));
endmodule

// File: tb/fram_col_ram_tb.sv
module fram_col_ram_tb;
  localparam int CLK_P = 10;
  localparam int NW    = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;

  int nchecks = 0;
  int nfail   = 0;
  logic [15:0] model [NW];

  always #(CLK_P/2) clk = ~clk;

  fram_col_ram u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata));

  function automatic logic [15:0] pat(input int a, input logic [15:0] salt);
    return 16'(a * 40503) ^ salt;
  endfunction

  function automatic int mk_addr(input int row, input int pos);
    return row * 8 + pos;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int a, input logic [15:0] d);
    addr = 11'(a); we = 1'b1; wdata = d;
    @(negedge clk);
    model[a] = d;
    we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    addr = 11'(a); we = 1'b0;
    @(negedge clk);
    chk(tag, rdata, model[a]);
  endtask

  task automatic wr_collide(input int a, input logic [15:0] d);
    logic [15:0] old;
    old = model[a];
    addr = 11'(a); we = 1'b1; wdata = d;
    @(negedge clk);
    chk("R7 read during write", rdata, old);
    model[a] = d;
    we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d2c3b4a);
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 reset value", rdata, 16'h0000);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill and read back every address
    for (int a = 0; a < NW; a++) wr(a, pat(a, 16'h5a5a));
    for (int a = 0; a < NW; a++) rd(a, "R1 fill readback");
    wr(0, 16'hffff);     rd(0, "R1 lowest address");
    wr(NW-1, 16'h0001);  rd(NW-1, "R1 highest address");

    // R2: eight distinct words in one row
    for (int p = 0; p < 8; p++) wr(mk_addr(17, p), 16'h1100 + 16'(p) * 16'h0101);
    for (int p = 0; p < 8; p++) rd(mk_addr(17, p), "R2 row positions");

    // R5: rewrite one slice, neighbours intact
    wr(mk_addr(17, 3), 16'hbeef);
    for (int p = 0; p < 8; p++) rd(mk_addr(17, p), "R5 slice isolation");

    // R3 and R4: write row 40 fully, rows 39 and 41 untouched
    for (int p = 0; p < 8; p++) wr(mk_addr(40, p), 16'hc000 | 16'(p));
    for (int p = 0; p < 8; p++) rd(mk_addr(41, p), "R4 next row kept");
    for (int p = 0; p < 8; p++) rd(mk_addr(39, p), "R3 single strobe");
    rd(mk_addr(255, 7), "R4 far row kept");

    // R6: write then immediate read, back-to-back reads
    wr(1234, 16'h7e57); rd(1234, "R6 read after write");
    rd(5, "R6 pipelined read"); rd(6, "R6 pipelined read"); rd(2040, "R6 pipelined read");
    addr = 11'd5; @(negedge clk); @(negedge clk);
    chk("R6 held output", rdata, model[5]);

    // R7: read during write shows the old word, then the new one
    wr_collide(777, 16'h4242);
    rd(777, "R7 new data next access");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int a;
      int op;
      a  = int'($urandom_range(NW-1, 0));
      op = int'($urandom_range(9, 0));
      if (op < 4)      wr(a, 16'($urandom()));
      else if (op < 5) wr_collide(a, 16'($urandom()));
      else             rd(a, "R1 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule